// File: doc/BRIEF.md
# Ring-Organised Debug Trace Buffer

This block records a stream of wide debug samples into a fixed number of rows that are used as a ring. One of four sample sources is picked by a 2-bit selector. Tracing is armed with a start pulse and ended with a stop pulse. While it is running, every cycle that carries a valid sample writes that sample into the current row and moves the write pointer on by one, wrapping after the last row.

Software reads the capture back through three word-wide registers: a control word, a low-data word and a high-data word. Each of the two data ports has its own row pointer, and a read of that port moves its pointer on by one row. When tracing stops, both pointers are placed on the oldest captured row. While tracing runs, data reads do not move either pointer, and the low-data word carries a flag that shows the trace is live.

A hold-off control keeps a new start request from arming the trace. It has no effect on a trace that is already running. A build parameter can remove the hold-off and the run-status bits.

Top module: `trace_ring`

## Requirements
- R1: After reset the control word reads 0, and reads of the low-data and high-data words return 0 with the running flag clear.
- R2: A start pulse, given while the trace is stopped and hold-off is clear, arms the trace on the next clock. Control bit 19 then reads 1, and low-data bit 63 (the running flag) reads 1 until tracing stops.
- R3: While hold-off (control bit 18) is set, a start pulse is ignored and the trace stays stopped.
- R4: Setting hold-off while the trace runs does not stop it. Only a stop pulse does.
- R5: While the trace runs, each cycle with sample_valid high and no stop stores the source picked by control bits 15:14 (source k at src_data[64k+63:64k]) into the current row and moves the write pointer on. Cycles without sample_valid store nothing.
- R6: While the trace runs, data-register reads move neither row pointer, so repeated reads return the same row.
- R7: A stop places both row pointers on the oldest row: row 0 if the ring has not wrapped since the start, otherwise the row the write pointer is on. A low-data read returns the row's bits 31:0 in bits 31:0 and moves the pointer on, wrapping from the last row back to row 0.
- R8: The high-data pointer is independent of the low-data pointer. After N low reads and ROWS-N further low reads, the low pointer is back where it began, and N high reads return bits 63:32 of the same rows, in the same order, in bits 31:0.
- R9: Control bits 15:14 and 18 can be written and read back. Bit 19 is read-only and shows the running state. All other control bits read 0.
- R10: With HAS_RUN_BITS=0, control bits 18 and 19 always read 0, writes to them are ignored, and start is never blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trace_start | input | 1 | Request to arm tracing |
| trace_stop | input | 1 | Request to end tracing (wins over start) |
| sample_valid | input | 1 | The current cycle carries a sample |
| src_data | input | 4*SAMPLE_W | Four sample sources, source k in slice k |
| reg_addr | input | 2 | Register select: 0 control, 1 low data, 2 high data |
| reg_rd | input | 1 | Read strobe; a read of a data port moves that port's pointer |
| reg_wr | input | 1 | Write strobe (control word only) |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for reg_addr, valid in the strobe cycle |

## Verification
The bench captures more samples than the ring has rows and leaves a gap with no valid sample. A design that stored invalid cycles, or that rewound to row 0 instead of the oldest row, would return the wrong sample numbers in the readout. It then walks the low pointer all the way round the ring before reading the high halves, which catches pointers that are shared between the ports or that wrap wrongly. While a trace is live it reads each data port several times and expects the same row every time, which catches a design that moves the pointer during a trace. It also starts a trace under hold-off and sets hold-off while a trace runs: a design that tied hold-off to a forced stop, or that let a start through under hold-off, would show the wrong status bit. A second build without the run bits must hide bits 18 and 19 and must start freely.

// File: rtl/trace_ring_pkg.sv
// Shared constants and register selector for the trace ring.
// Assumes the register words are at least 20 bits wide.
package trace_ring_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2
    } reg_sel_e;

    localparam int CTRL_MUX_LSB = 14;
    localparam int CTRL_HOLD    = 18;
    localparam int CTRL_STATUS  = 19;
    localparam int NUM_SRC      = 4;
endpackage

// File: rtl/trace_ctrl.sv
// Run/stop state, hold-off and source select for the trace ring.
// A stop wins over a start in the same cycle. A start is accepted only while
// stopped and not held off. Hold-off never forces a stop.
module trace_ctrl
    import trace_ring_pkg::*;
#(
    parameter int HAS_RUN_BITS = 1,
    parameter int REG_W        = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trace_start,
    input  logic             trace_stop,
    input  logic             ctrl_wr,
    input  logic [1:0]       wr_mux,
    input  logic             wr_hold,
    output logic             running,
    output logic             holdoff,
    output logic [1:0]       mux_sel,
    output logic             start_ok,
    output logic             stop_ok,
    output logic [REG_W-1:0] ctrl_rdata
);
    assign start_ok = trace_start && !trace_stop && !running && !holdoff;
    assign stop_ok  = trace_stop && running;

    // Run state: set by an accepted start, cleared by a stop.
    always_ff @(posedge clk) begin
        if (!rst_n)       running <= 1'b0;
        else if (stop_ok) running <= 1'b0;
        else if (start_ok) running <= 1'b1;
    end

    // Source select, written through the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)       mux_sel <= 2'b00;
        else if (ctrl_wr) mux_sel <= wr_mux;
    end

    generate
        if (HAS_RUN_BITS != 0) begin : g_hold
            // Hold-off flag, written through the control word.
            always_ff @(posedge clk) begin
                if (!rst_n)       holdoff <= 1'b0;
                else if (ctrl_wr) holdoff <= wr_hold;
            end
        end else begin : g_nohold
            logic unused_wr_hold;
            assign unused_wr_hold = wr_hold;
            assign holdoff        = 1'b0;
        end
    endgenerate

    // Assemble the control word seen by software.
    always_comb begin
        ctrl_rdata = '0;
        ctrl_rdata[CTRL_MUX_LSB +: 2] = mux_sel;
        if (HAS_RUN_BITS != 0) begin
            ctrl_rdata[CTRL_HOLD]   = holdoff;
            ctrl_rdata[CTRL_STATUS] = running;
        end
    end
endmodule

// File: rtl/trace_store.sv
// Row storage and write pointer of the trace ring.
// A start rewinds the write pointer to row 0 and clears the wrap flag. The
// oldest row is row 0 until the ring wraps, and the write pointer after that.
module trace_store #(
    parameter int ROWS     = 16,
    parameter int SAMPLE_W = 64,
    parameter int PTR_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_ok,
    input  logic                  cap_en,
    input  logic [SAMPLE_W-1:0]   sample,
    input  logic [PTR_W-1:0]      rd_lo_ptr,
    input  logic [PTR_W-1:0]      rd_hi_ptr,
    output logic [PTR_W-1:0]      wr_ptr,
    output logic [PTR_W-1:0]      oldest_ptr,
    output logic [SAMPLE_W/2-1:0] lo_half,
    output logic [SAMPLE_W/2-1:0] hi_half
);
    localparam int HALF_W = SAMPLE_W / 2;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ROWS - 1);

    logic [SAMPLE_W-1:0] rows_q [ROWS];
    logic                wrapped;

    // Capture samples into the ring and track the write position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            wrapped <= 1'b0;
            for (int i = 0; i < ROWS; i++) rows_q[i] <= '0;
        end else if (start_ok) begin
            wr_ptr  <= '0;
            wrapped <= 1'b0;
        end else if (cap_en) begin
            rows_q[wr_ptr] <= sample;
            wr_ptr         <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (wr_ptr == LAST) wrapped <= 1'b1;
        end
    end

    assign oldest_ptr = wrapped ? wr_ptr : '0;
    assign lo_half    = rows_q[rd_lo_ptr][HALF_W-1:0];
    assign hi_half    = rows_q[rd_hi_ptr][SAMPLE_W-1:HALF_W];
endmodule

// File: rtl/trace_readout.sv
// Independent low and high read pointers of the trace ring.
// A stop loads both with the oldest row. A data read moves its own pointer
// on by one, wrapping, and only while the trace is stopped.
module trace_readout #(
    parameter int ROWS  = 16,
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             stop_ok,
    input  logic [PTR_W-1:0] oldest_ptr,
    input  logic             lo_rd,
    input  logic             hi_rd,
    output logic [PTR_W-1:0] rd_lo_ptr,
    output logic [PTR_W-1:0] rd_hi_ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ROWS - 1);

    // Low-data pointer: rewound by a stop, moved on by low reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rd_lo_ptr <= '0;
        else if (stop_ok)            rd_lo_ptr <= oldest_ptr;
        else if (lo_rd && !running)  rd_lo_ptr <= (rd_lo_ptr == LAST) ? '0 : rd_lo_ptr + 1'b1;
    end

    // High-data pointer: rewound by a stop, moved on by high reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rd_hi_ptr <= '0;
        else if (stop_ok)            rd_hi_ptr <= oldest_ptr;
        else if (hi_rd && !running)  rd_hi_ptr <= (rd_hi_ptr == LAST) ? '0 : rd_hi_ptr + 1'b1;
    end
endmodule

// File: rtl/trace_ring.sv
// Top of the ring trace buffer: source select, register decode and read data.
// Assumes REG_W > SAMPLE_W/2 so that the running flag sits above the low half.
// Read data is combinational on reg_addr. Pointer side effects happen at the
// clock edge that ends the strobe cycle.
module trace_ring
    import trace_ring_pkg::*;
#(
    parameter int ROWS         = 16,
    parameter int SAMPLE_W     = 64,
    parameter int REG_W        = 64,
    parameter int HAS_RUN_BITS = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        trace_start,
    input  logic                        trace_stop,
    input  logic                        sample_valid,
    input  logic [NUM_SRC*SAMPLE_W-1:0] src_data,
    input  logic [1:0]                  reg_addr,
    input  logic                        reg_rd,
    input  logic                        reg_wr,
    input  logic [REG_W-1:0]            reg_wdata,
    output logic [REG_W-1:0]            reg_rdata
);
    localparam int PTR_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int HALF_W = SAMPLE_W / 2;

    logic                running, holdoff, start_ok, stop_ok, cap_en;
    logic [1:0]          mux_sel;
    logic [REG_W-1:0]    ctrl_rdata;
    logic [PTR_W-1:0]    wr_ptr, oldest_ptr, rd_lo_ptr, rd_hi_ptr;
    logic [HALF_W-1:0]   lo_half, hi_half;
    logic [SAMPLE_W-1:0] src_arr [NUM_SRC];
    logic [SAMPLE_W-1:0] sample;
    logic                ctrl_wr, lo_rd, hi_rd;
    logic                unused_wdata;

    assign ctrl_wr = reg_wr && (reg_addr == SEL_CTRL);
    assign lo_rd   = reg_rd && (reg_addr == SEL_LO);
    assign hi_rd   = reg_rd && (reg_addr == SEL_HI);
    assign unused_wdata = ^reg_wdata;

    generate
        for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
            assign src_arr[k] = src_data[k*SAMPLE_W +: SAMPLE_W];
        end
    endgenerate

    assign sample = src_arr[mux_sel];
    assign cap_en = running && sample_valid && !trace_stop;

    trace_ctrl #(.HAS_RUN_BITS(HAS_RUN_BITS), .REG_W(REG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .trace_start(trace_start), .trace_stop(trace_stop),
        .ctrl_wr(ctrl_wr),
        .wr_mux(reg_wdata[CTRL_MUX_LSB +: 2]),
        .wr_hold(reg_wdata[CTRL_HOLD]),
        .running(running), .holdoff(holdoff), .mux_sel(mux_sel),
        .start_ok(start_ok), .stop_ok(stop_ok),
        .ctrl_rdata(ctrl_rdata)
    );

    trace_store #(.ROWS(ROWS), .SAMPLE_W(SAMPLE_W), .PTR_W(PTR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .start_ok(start_ok), .cap_en(cap_en), .sample(sample),
        .rd_lo_ptr(rd_lo_ptr), .rd_hi_ptr(rd_hi_ptr),
        .wr_ptr(wr_ptr), .oldest_ptr(oldest_ptr),
        .lo_half(lo_half), .hi_half(hi_half)
    );

    trace_readout #(.ROWS(ROWS), .PTR_W(PTR_W)) u_readout (
        .clk(clk), .rst_n(rst_n),
        .running(running), .stop_ok(stop_ok), .oldest_ptr(oldest_ptr),
        .lo_rd(lo_rd), .hi_rd(hi_rd),
        .rd_lo_ptr(rd_lo_ptr), .rd_hi_ptr(rd_hi_ptr)
    );

    // Read data selected by the register address.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_CTRL: reg_rdata = ctrl_rdata;
            SEL_LO: begin
                reg_rdata[HALF_W-1:0] = lo_half;
                reg_rdata[REG_W-1]    = running;
            end
            SEL_HI:  reg_rdata[HALF_W-1:0] = hi_half;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/trace_ring_chk.sv
// Temporal checks on the trace ring, attached to every instance by bind.
module trace_ring_chk #(
    parameter int ROWS         = 16,
    parameter int PTR_W        = 4,
    parameter int HAS_RUN_BITS = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trace_start,
    input logic             trace_stop,
    input logic             sample_valid,
    input logic             running,
    input logic             holdoff,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_lo_ptr,
    input logic [PTR_W-1:0] rd_hi_ptr
);
    // R2: a clean start request arms the trace
    assert_start_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_start && !trace_stop && !running && !holdoff) |=> running);

    // R3: held off and stopped stays stopped
    assert_hold_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && holdoff) |=> !running);

    // R4: only a stop ends a running trace
    assert_run_persists_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !trace_stop) |=> running);

    // R5: each valid running cycle moves the write pointer on by one
    assert_wr_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && sample_valid && !trace_stop) |=>
        (wr_ptr == (($past(wr_ptr) == PTR_W'(ROWS - 1)) ? '0 : $past(wr_ptr) + 1'b1)));

    // R6: read pointers are frozen while tracing
    assert_ptr_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !trace_stop) |=> ($stable(rd_lo_ptr) && $stable(rd_hi_ptr)));

    // R7: a stop puts both pointers on the same row
    assert_stop_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && trace_stop) |=> (rd_lo_ptr == rd_hi_ptr));

    // R10: the build without run bits never holds off
    assert_no_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_RUN_BITS == 0) |-> !holdoff);
endmodule

bind trace_ring trace_ring_chk #(.ROWS(ROWS), .PTR_W(PTR_W), .HAS_RUN_BITS(HAS_RUN_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .trace_start(trace_start), .trace_stop(trace_stop),
    .sample_valid(sample_valid), .running(running), .holdoff(holdoff),
    .wr_ptr(wr_ptr), .rd_lo_ptr(rd_lo_ptr), .rd_hi_ptr(rd_hi_ptr)
);

// File: tb/tb_trace_ring.sv
// Self-checking bench for trace_ring: a control-word vector table, then
// directed capture, wrap, freeze, hold-off and variant tests.
module tb_trace_ring;
    localparam int ROWS = 16;
    localparam int SW   = 64;
    localparam int RW   = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trace_start = 1'b0, trace_stop = 1'b0, sample_valid = 1'b0;
    logic [4*SW-1:0] src_data = '0;
    logic [1:0]      reg_addr = 2'd0;
    logic            reg_rd = 1'b0, reg_wr = 1'b0;
    logic [RW-1:0]   reg_wdata = '0;
    logic [RW-1:0]   reg_rdata, rdata_nv;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trace_ring #(.ROWS(ROWS), .SAMPLE_W(SW), .REG_W(RW), .HAS_RUN_BITS(1)) dut (
        .clk(clk), .rst_n(rst_n), .trace_start(trace_start), .trace_stop(trace_stop),
        .sample_valid(sample_valid), .src_data(src_data), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    trace_ring #(.ROWS(ROWS), .SAMPLE_W(SW), .REG_W(RW), .HAS_RUN_BITS(0)) dut_nv (
        .clk(clk), .rst_n(rst_n), .trace_start(trace_start), .trace_stop(trace_stop),
        .sample_valid(sample_valid), .src_data(src_data), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rdata_nv));

    // Control-word vectors for R9: {write value, expected readback}
    localparam logic [127:0] CTRL_VEC [6] = '{
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0004_C000},
        {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        {64'h0000_0000_0008_0000, 64'h0000_0000_0000_0000},
        {64'h0000_0000_0004_4000, 64'h0000_0000_0004_4000},
        {64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000},
        {64'h0000_0000_FFFB_3FFF, 64'h0000_0000_0000_0000}
    };

    function automatic logic [63:0] pat(input int n, input int s);
        return {8'(s) + 8'hA0, 24'(n), 8'(s) + 8'h50, 24'(n * 3 + 7)};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr_ctrl(input logic [63:0] d);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] v, output logic [63:0] vn);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        v = reg_rdata; vn = rdata_nv;
        step();
        reg_rd = 1'b0;
    endtask

    task automatic pulse_start();
        trace_start = 1'b1; step(); trace_start = 1'b0;
    endtask

    task automatic pulse_stop();
        trace_stop = 1'b1; step(); trace_stop = 1'b0;
    endtask

    task automatic feed(input int n, input logic vld);
        for (int s = 0; s < 4; s++) src_data[s*SW +: SW] = pat(n, s);
        sample_valid = vld;
        step();
        sample_valid = 1'b0;
    endtask

    function automatic logic [63:0] lo_word(input logic flag, input int n, input int s);
        logic [63:0] w = pat(n, s);
        return {flag, 31'd0, w[31:0]};
    endfunction

    function automatic logic [63:0] hi_word(input int n, input int s);
        logic [63:0] w = pat(n, s);
        return {32'd0, w[63:32]};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] v, vn;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        rd(2'd0, v, vn); check("R1 ctrl", v, 64'd0);
        rd(2'd1, v, vn); check("R1 lo", v, 64'd0);
        rd(2'd2, v, vn); check("R1 hi", v, 64'd0);

        // R9: control-word vector table
        for (int i = 0; i < 6; i++) begin
            wr_ctrl(CTRL_VEC[i][127:64]);
            rd(2'd0, v, vn);
            check("R9 ctrl vector", v, CTRL_VEC[i][63:0]);
        end

        // R5/R7/R8: wrapped capture from source 2
        wr_ctrl(64'h8000);
        pulse_start();
        rd(2'd0, v, vn); check("R2 status", 64'(v[19]), 64'd1);
        for (int n = 0; n < 20; n++) begin
            feed(n, 1'b1);
            if (n == 10) feed(99, 1'b0);
        end
        pulse_stop();
        rd(2'd0, v, vn); check("R2 status off", 64'(v[19]), 64'd0);
        for (int i = 0; i < 5; i++) begin
            rd(2'd1, v, vn); check("R7 oldest-first lo", v, lo_word(1'b0, 4 + i, 2));
        end
        for (int i = 0; i < ROWS - 5; i++) rd(2'd1, v, vn);
        for (int i = 0; i < 5; i++) begin
            rd(2'd2, v, vn); check("R8 hi order", v, hi_word(4 + i, 2));
        end
        rd(2'd1, v, vn); check("R8 lo pointer back", v, lo_word(1'b0, 4, 2));
        for (int i = 0; i < 15; i++) rd(2'd1, v, vn);
        check("R5 newest row", v, lo_word(1'b0, 19, 2));
        rd(2'd1, v, vn); check("R7 lo wraps", v, lo_word(1'b0, 4, 2));

        // R7: capture without wrap, source 1
        wr_ctrl(64'h4000);
        pulse_start();
        for (int n = 0; n < 3; n++) feed(n, 1'b1);
        pulse_stop();
        rd(2'd1, v, vn); check("R7 unwrapped origin", v, lo_word(1'b0, 0, 1));
        rd(2'd2, v, vn); check("R5 source 1 hi", v, hi_word(0, 1));

        // R6: pointers frozen while running
        pulse_start();
        for (int i = 0; i < 3; i++) begin
            rd(2'd1, v, vn); check("R6 lo frozen", v, lo_word(1'b1, 1, 1));
        end
        for (int i = 0; i < 2; i++) begin
            rd(2'd2, v, vn); check("R6 hi frozen", v, hi_word(1, 1));
        end

        // R4: hold-off set while running keeps running
        wr_ctrl(64'h4_4000);
        step(); step();
        rd(2'd0, v, vn); check("R4 still running", v, 64'hC_4000);
        pulse_stop();
        rd(2'd0, v, vn); check("R4 stopped by stop", v, 64'h4_4000);

        // R3: start blocked under hold-off
        pulse_start();
        step();
        rd(2'd0, v, vn); check("R3 start blocked", v, 64'h4_4000);
        rd(2'd1, v, vn); check("R3 flag clear", v, lo_word(1'b0, 0, 1));
        wr_ctrl(64'h4000);
        pulse_start();
        rd(2'd0, v, vn); check("R2 start after release", v, 64'h8_4000);
        pulse_stop();

        // R10: build without run bits
        wr_ctrl(64'hC_4000);
        rd(2'd0, v, vn);
        check("R10 bits hidden", vn, 64'h4000);
        check("R9 bit19 read-only", v, 64'h4_4000);
        pulse_start();
        rd(2'd1, v, vn);
        check("R10 start not blocked", 64'(vn[63]), 64'd1);
        check("R3 main build blocked", 64'(v[63]), 64'd0);
        rd(2'd0, v, vn); check("R10 status hidden", vn, 64'h4000);
        pulse_stop();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule